// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external byte-wide asynchronous static RAM with a 19-bit address, an 8-bit data bus and three active-low strobes (chip select, output enable, write strobe). The host hands over one request at a time through a valid/ready pair carrying an address, a write flag and a write byte. The controller turns that request into a strobe sequence that obeys the RAM's nanosecond timing rules. It reports completion with a one-cycle done pulse, and on reads it also returns the byte it sampled.

All RAM timing limits are stored in nanoseconds for three selectable speed grades (45, 55 and 70 ns cycle). They are turned into wait-state counts at elaboration from the clock period. The data bus is split into an output byte, an input byte and a drive-enable, and the pad ring builds the tristate buffer from these.

A power-down input parks the RAM with chip select high for data retention. When the input is released, the controller waits out one read-cycle time before it accepts any new request.

Top module: `asc_sram_ctl`

## Requirements
- R1: After reset, and in every cycle where `req_ready` is high, the three strobes are high (standby) and `sram_dq_oe` is low.
- R2: `sram_addr` changes only on a clock edge where chip select and the write strobe were both high in the cycle before.
- R3: A read holds chip select and output enable low, with the write strobe high, for RD = max(ceil(tAA/T), ceil(tOE/T), ceil(tRC/T)) cycles. The bus is sampled at the end of the last such cycle. `rsp_done` is first seen RD+1 cycles after the accepting edge, with `rsp_rdata` equal to the byte stored at that address.
- R4: A write first keeps chip select low with output enable and the write strobe high for GAP = max(1, ceil(tOHZ/T)) cycles. It then holds the write strobe low for PW = max(ceil(tWP/T), ceil(tAW/T), ceil(tCW/T), ceil(tDW/T), ceil(tWC/T) - GAP) cycles, and `rsp_done` is first seen GAP+PW+1 cycles after the accepting edge.
- R5: `sram_dq_oe` is high exactly while the write strobe is low, it is never high while output enable is low, and `sram_dq_o` carries the request's write byte during that time.
- R6: `req_ready` is high only when the controller is idle and `pd_req` is low. A request presented while `req_ready` is low is ignored and leaves both the pins and the RAM contents untouched.
- R7: While `pd_req` is high and no access is in progress, chip select stays high, `req_ready` stays low, and requests have no effect. An access that is already in progress when `pd_req` rises completes normally.
- R8: After `pd_req` falls, `req_ready` rises REC+1 cycles later, where REC = max(1, ceil(tRC/T)).
- R9: Each timing value converts to cycles as ceil(ns / clock period), and a 0 ns value gives no wait state. The speed-grade parameter picks the 45, 55 or 70 ns value set, and any other value falls back to the 45 ns set.
- R10: `rsp_done` is high for exactly one cycle per completed access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | RAM byte address |
| req_wdata | input | 8 | Byte to write |
| pd_req | input | 1 | Power-down hold request |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte returned by the last read |
| sram_addr | output | 19 | RAM address lines |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_dq_o | output | 8 | Byte driven toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data bus |
| sram_dq_i | input | 8 | Byte read from the RAM bus |

## Verification
A sequencer stuck in the wrong state or holding the wrong count shows up within one access as a strobe pulse of the wrong length, and the bench's cycle-level RAM model flags that at the edge where the strobe releases. A read sampled too early returns a filler byte on the next done pulse instead of the stored byte. A corrupted address or data register surfaces only on the later read of that location, so every location written in the sweep is read back. A recovery or hold fault shows as `req_ready` returning on the wrong cycle after power-down, or never returning at all.

// File: rtl/asc_pkg.sv
package asc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WGAP,
        ST_WPULSE,
        ST_HOLD,
        ST_RECOV
    } asc_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } asc_pins_t;

    typedef struct packed {
        int rc;
        int aa;
        int oe;
        int ohz;
        int wc;
        int aw;
        int cw;
        int wp;
        int dw;
    } asc_ns_t;

    function automatic asc_ns_t grade_ns(input int grade);
        asc_ns_t t;
        case (grade)
            55:      t = '{rc:55, aa:55, oe:30, ohz:20, wc:55, aw:50, cw:50, wp:45, dw:25};
            70:      t = '{rc:70, aa:70, oe:35, ohz:25, wc:70, aw:60, cw:60, wp:55, dw:30};
            default: t = '{rc:45, aa:45, oe:25, ohz:15, wc:45, aw:40, cw:40, wp:35, dw:20};
        endcase
        return t;
    endfunction

    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns <= 0) ? 0 : (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int read_cycles(input int grade, input int clk_ns);
        asc_ns_t t = grade_ns(grade);
        return imax(1, imax(imax(ns_to_cyc(t.aa, clk_ns), ns_to_cyc(t.oe, clk_ns)),
                            ns_to_cyc(t.rc, clk_ns)));
    endfunction

    function automatic int gap_cycles(input int grade, input int clk_ns);
        asc_ns_t t = grade_ns(grade);
        return imax(1, ns_to_cyc(t.ohz, clk_ns));
    endfunction

    function automatic int pulse_cycles(input int grade, input int clk_ns);
        asc_ns_t t = grade_ns(grade);
        int w;
        w = imax(ns_to_cyc(t.wp, clk_ns), ns_to_cyc(t.dw, clk_ns));
        w = imax(w, imax(ns_to_cyc(t.aw, clk_ns), ns_to_cyc(t.cw, clk_ns)));
        w = imax(w, ns_to_cyc(t.wc, clk_ns) - gap_cycles(grade, clk_ns));
        return imax(1, w);
    endfunction

    function automatic int recov_cycles(input int grade, input int clk_ns);
        asc_ns_t t = grade_ns(grade);
        return imax(1, ns_to_cyc(t.rc, clk_ns));
    endfunction

    function automatic asc_pins_t pins_for(input asc_state_e s);
        asc_pins_t p;
        p = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
        case (s)
            ST_READ:   begin p.ce_n = 1'b0; p.oe_n = 1'b0; end
            ST_WGAP:   p.ce_n = 1'b0;
            ST_WPULSE: begin p.ce_n = 1'b0; p.we_n = 1'b0; p.drive = 1'b1; end
            default:   p = p;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asc_wait_ctr.sv
module asc_wait_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_cnt,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= load_cnt;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/asc_fsm.sv
module asc_fsm
    import asc_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int RD_CYC  = 6,
    parameter int GAP_CYC = 2,
    parameter int PW_CYC  = 5,
    parameter int REC_CYC = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             pd_req,
    input  logic             last,
    output logic             req_ready,
    output logic             accept,
    output logic             ctr_load,
    output logic [CNT_W-1:0] ctr_val,
    output logic             rd_cap,
    output logic             acc_end,
    output asc_pins_t        pins
);
    localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GAP_CYC - 1);
    localparam logic [CNT_W-1:0] PW_LD  = CNT_W'(PW_CYC - 1);
    localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);

    asc_state_e state_q, state_d;

    assign req_ready = (state_q == ST_IDLE) && !pd_req;
    assign accept    = req_ready && req_valid;

    always_comb begin
        state_d  = state_q;
        ctr_load = 1'b0;
        ctr_val  = '0;
        rd_cap   = 1'b0;
        acc_end  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (pd_req) begin
                    state_d = ST_HOLD;
                end else if (req_valid) begin
                    ctr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WGAP;
                        ctr_val = GAP_LD;
                    end else begin
                        state_d = ST_READ;
                        ctr_val = RD_LD;
                    end
                end
            end
            ST_READ: if (last) begin
                state_d = ST_IDLE;
                rd_cap  = 1'b1;
                acc_end = 1'b1;
            end
            ST_WGAP: if (last) begin
                state_d  = ST_WPULSE;
                ctr_load = 1'b1;
                ctr_val  = PW_LD;
            end
            ST_WPULSE: if (last) begin
                state_d = ST_IDLE;
                acc_end = 1'b1;
            end
            ST_HOLD: if (!pd_req) begin
                state_d  = ST_RECOV;
                ctr_load = 1'b1;
                ctr_val  = REC_LD;
            end
            ST_RECOV: if (last) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins    <= pins_for(ST_IDLE);
        end else begin
            state_q <= state_d;
            pins    <= pins_for(state_d);
        end
    end
endmodule

// File: rtl/asc_datapath.sv
module asc_datapath #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          rd_cap,
    input  logic          acc_end,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q,
    output logic          done_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (rd_cap) rdata_q <= dq_in;
            done_q <= acc_end;
        end
    end
endmodule

// File: rtl/asc_sram_ctl.sv
module asc_sram_ctl
    import asc_pkg::*;
#(
    parameter int CLK_NS      = 8,
    parameter int SPEED_GRADE = 45,
    parameter int AW          = 19,
    parameter int DW          = 8,
    parameter int CNT_W       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          pd_req,
    output logic          rsp_done,
    output logic [DW-1:0] rsp_rdata,
    output logic [AW-1:0] sram_addr,
    output logic          sram_ce_n,
    output logic          sram_oe_n,
    output logic          sram_we_n,
    output logic [DW-1:0] sram_dq_o,
    output logic          sram_dq_oe,
    input  logic [DW-1:0] sram_dq_i
);
    localparam int RD_CYC  = read_cycles(SPEED_GRADE, CLK_NS);
    localparam int GAP_CYC = gap_cycles(SPEED_GRADE, CLK_NS);
    localparam int PW_CYC  = pulse_cycles(SPEED_GRADE, CLK_NS);
    localparam int REC_CYC = recov_cycles(SPEED_GRADE, CLK_NS);

    logic             accept, ctr_load, last, rd_cap, acc_end;
    logic [CNT_W-1:0] ctr_val;
    asc_pins_t        pins;

    asc_fsm #(
        .CNT_W(CNT_W), .RD_CYC(RD_CYC), .GAP_CYC(GAP_CYC),
        .PW_CYC(PW_CYC), .REC_CYC(REC_CYC)
    ) u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .pd_req(pd_req), .last(last), .req_ready(req_ready), .accept(accept),
        .ctr_load(ctr_load), .ctr_val(ctr_val), .rd_cap(rd_cap),
        .acc_end(acc_end), .pins(pins)
    );

    asc_wait_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst(rst), .load(ctr_load), .load_cnt(ctr_val), .last(last)
    );

    asc_datapath #(.AW(AW), .DW(DW)) u_dp (
        .clk(clk), .rst(rst), .accept(accept), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_cap(rd_cap), .acc_end(acc_end),
        .dq_in(sram_dq_i), .addr_q(sram_addr), .wdata_q(sram_dq_o),
        .rdata_q(rsp_rdata), .done_q(rsp_done)
    );

    assign sram_ce_n  = pins.ce_n;
    assign sram_oe_n  = pins.oe_n;
    assign sram_we_n  = pins.we_n;
    assign sram_dq_oe = pins.drive;
endmodule

// File: rtl/asc_sram_ctl_chk.sv
module asc_sram_ctl_chk #(
    parameter int AW = 19
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          pd_req,
    input logic          rsp_done,
    input logic [AW-1:0] sram_addr,
    input logic          sram_ce_n,
    input logic          sram_oe_n,
    input logic          sram_we_n,
    input logic          sram_dq_oe
);
    a_r1_quiet_when_ready: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

    a_r2_addr_moves_between_strobes: assert property (@(posedge clk) disable iff (rst)
        (sram_addr != $past(sram_addr)) |-> ($past(sram_ce_n) && $past(sram_we_n)));

    a_r3_read_pins: assert property (@(posedge clk) disable iff (rst)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    a_r4_write_oe_high: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n));

    a_r4_gap_before_pulse: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n) |-> ($past(!sram_ce_n) && $past(sram_oe_n)));

    a_r5_drive_in_pulse: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> !sram_we_n);

    a_r5_pulse_drives: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> sram_dq_oe);

    a_r7_no_ready_in_pd: assert property (@(posedge clk) disable iff (rst)
        pd_req |-> !req_ready);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
endmodule

bind asc_sram_ctl asc_sram_ctl_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .pd_req(pd_req),
    .rsp_done(rsp_done), .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dq_oe(sram_dq_oe)
);

// File: tb/tb_asc_sram_ctl.sv
module tb_asc_sram_ctl;
    localparam int CLK_NS = 8;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // 45 ns grade expectations (R9)
    localparam int E_RD  = mx(mx(cdiv(45, CLK_NS), cdiv(25, CLK_NS)), cdiv(45, CLK_NS));
    localparam int E_GAP = mx(1, cdiv(15, CLK_NS));
    localparam int E_PW  = mx(mx(cdiv(35, CLK_NS), cdiv(20, CLK_NS)),
                              mx(cdiv(40, CLK_NS), cdiv(45, CLK_NS) - E_GAP));
    localparam int E_REC = mx(1, cdiv(45, CLK_NS));

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, pd_req = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_done, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
    logic [7:0]  rsp_rdata, sram_dq_o;
    logic [7:0]  sram_dq_i = 8'hEE;
    logic [18:0] sram_addr;

    always #(CLK_NS/2) clk = ~clk;

    asc_sram_ctl dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .pd_req(pd_req), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // cycle-level RAM model with timing checker (sampled at negedge)
    logic [7:0]  mem [256];
    logic [18:0] cur_addr = '0;
    int ce_cnt = 0, oe_cnt = 0, oe_hi_cnt = 100, we_cnt = 0;
    logic [7:0]  wr_byte;
    logic [18:0] wr_addr;

    initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

    always @(negedge clk) begin
        if (!rst) begin
            ce_cnt    = sram_ce_n ? 0 : ce_cnt + 1;
            oe_cnt    = sram_oe_n ? 0 : oe_cnt + 1;
            oe_hi_cnt = sram_oe_n ? ((oe_hi_cnt < 100) ? oe_hi_cnt + 1 : 100) : 0;
            if (!sram_ce_n && sram_addr != cur_addr)
                chk(1'b0, "R2 address on pins", int'(sram_addr), int'(cur_addr));
            if (sram_dq_oe && we_cnt == 0)  // first drive cycle: R5 turn-off gap
                chk(!sram_oe_n == 1'b0 && oe_hi_cnt * CLK_NS >= 15 + CLK_NS,
                    "R5 bus turn-off before drive", oe_hi_cnt, E_GAP + 1);
            if (!sram_we_n) begin
                we_cnt++;
                wr_byte = sram_dq_o;
                wr_addr = sram_addr;
                if (!sram_dq_oe) chk(1'b0, "R5 drive during pulse", 0, 1);
            end else if (we_cnt > 0) begin
                chk(we_cnt * CLK_NS >= 40 && we_cnt == E_PW, "R4 write pulse width", we_cnt, E_PW);
                mem[wr_addr[7:0]] = wr_byte;
                we_cnt = 0;
            end
            if (!sram_ce_n && !sram_oe_n && sram_we_n &&
                ce_cnt * CLK_NS >= 45 && oe_cnt * CLK_NS >= 25)
                sram_dq_i = mem[sram_addr[7:0]];
            else
                sram_dq_i = 8'hEE;
        end
    end

    task automatic access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                          output int lat);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        cur_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_done && lat < 100) begin @(negedge clk); lat++; end
        @(negedge clk);
        chk(rsp_done == 1'b0, "R10 done single cycle", int'(rsp_done), 0);
    endtask

    function automatic logic [18:0] addr_of(input int i);
        return {11'(i * 37 + 5), 8'(i)};
    endfunction

    initial begin
        #(200000 * CLK_NS);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int lat;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes high after reset",
            {sram_ce_n, sram_oe_n, sram_we_n}, 7);
        chk(!sram_dq_oe, "R1 drive off after reset", int'(sram_dq_oe), 0);
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

        // R4/R9: write sweep
        for (int i = 0; i < 64; i++) begin
            access(1'b1, addr_of(i), 8'(i * 3 + 1), lat);
            chk(lat == E_GAP + E_PW + 1, "R4 write latency", lat, E_GAP + E_PW + 1);
        end
        // R3/R9: read sweep
        for (int i = 0; i < 64; i++) begin
            access(1'b0, addr_of(i), 8'h00, lat);
            chk(lat == E_RD + 1, "R3 read latency", lat, E_RD + 1);
            chk(rsp_rdata == 8'(i * 3 + 1), "R3 read data", int'(rsp_rdata), (i * 3 + 1) & 255);
        end

        // R6: request held while busy is ignored
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = addr_of(10);
        cur_addr  = addr_of(10);
        @(negedge clk);
        req_write = 1'b1; req_addr = addr_of(11); req_wdata = 8'h5A;
        for (int k = 0; k < 3; k++) begin
            chk(!req_ready, "R6 ready low while busy", int'(req_ready), 0);
            @(negedge clk);
        end
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        chk(rsp_rdata == 8'(10 * 3 + 1), "R6 first read unaffected", int'(rsp_rdata), 31);
        access(1'b0, addr_of(11), 8'h00, lat);
        chk(rsp_rdata == 8'(11 * 3 + 1), "R6 ignored write left RAM", int'(rsp_rdata), 34);

        // R7: power-down hold ignores requests
        pd_req = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = addr_of(12); req_wdata = 8'hA5;
        begin
            bit quiet = 1'b1;
            for (int k = 0; k < 10; k++) begin
                if (!sram_ce_n || req_ready) quiet = 1'b0;
                @(negedge clk);
            end
            chk(quiet, "R7 hold keeps chip select high", int'(quiet), 1);
        end
        req_valid = 1'b0;
        // R8: recovery count
        pd_req = 1'b0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!req_ready && lat < 100);
        chk(lat == E_REC + 1, "R8 recovery before ready", lat, E_REC + 1);
        access(1'b0, addr_of(12), 8'h00, lat);
        chk(rsp_rdata == 8'(12 * 3 + 1), "R7 request in hold ignored", int'(rsp_rdata), 37);

        // R7: power-down raised mid-access lets the access finish
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = addr_of(20); req_wdata = 8'hC3;
        cur_addr  = addr_of(20);
        @(negedge clk);
        req_valid = 1'b0; pd_req = 1'b1;
        lat = 1;
        while (!rsp_done && lat < 100) begin @(negedge clk); lat++; end
        chk(lat == E_GAP + E_PW + 1, "R7 access completes under pd", lat, E_GAP + E_PW + 1);
        repeat (3) @(negedge clk);
        chk(sram_ce_n && !req_ready, "R7 hold entered after access", int'(req_ready), 0);
        pd_req = 1'b0;
        access(1'b0, addr_of(20), 8'h00, lat);
        chk(rsp_rdata == 8'hC3, "R4 write under pd stored", int'(rsp_rdata), 8'hC3);

        // R3: overwrite then read back
        access(1'b1, addr_of(5), 8'h77, lat);
        access(1'b0, addr_of(5), 8'h00, lat);
        chk(rsp_rdata == 8'h77, "R3 overwrite read back", int'(rsp_rdata), 8'h77);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule